// File: doc/BRIEF.md
# Infrared Code Window Matcher

This block receives pulse-distance infrared frames on one or more input pins, decodes each frame into a data word and compares that word with a small table of programmed wake values. Every received segment is timed in prescaled clock ticks. Each segment class has its own programmable acceptance window, and the segment's width must fall inside that window. The classes are the leader's low burst, the leader's high gap, the low burst of a data bit, and the high gap of a data bit, which differs for a 0 and for a 1.

A frame is a leader followed by `CODE_W` data bits, with the first received bit placed in bit 0 of the word. After the last bit the decoded word is published on that channel's code output. If the word equals one of the active table entries and matching is enabled for the channel, that channel's wake interrupt bit pulses for one cycle. The windows, the table and the entry count are shared by all channels. Each channel has its own decoder, its own enable, its own code output and its own interrupt bit. The line idles high.

Top module: `ir_wake_matcher`

## Requirements
- R1: During and right after reset every `wake_irq` bit is 0 and every `code_o` word is 0.
- R2: A frame consists of a leader low and a leader high, each inside its window, followed by `CODE_W` bits. Each bit is a low inside the data-low window, then a high inside the zero-high or one-high window, and that high ends with a falling edge. Such a frame updates the channel's `code_o` slice, with the first bit received placed in bit 0.
- R3: Windows pack the minimum in bits `[WID_W-1:0]` and the maximum in bits `[2*WID_W-1:WID_W]`. A width equal to the minimum or to the maximum is accepted, and a width one below the minimum is rejected.
- R4: A leader low whose width lies outside its window discards the frame: `code_o` keeps its value and no interrupt is raised.
- R5: A data-bit high that lies in neither the zero window nor the one window aborts the frame, and `code_o` keeps its value.
- R6: When a completed word equals table entry j (bits `[j*CODE_W +: CODE_W]` of `match_tbl`) with j < `match_cnt`, `wake_irq[i]` is high for exactly one cycle. That cycle is the same one in which the new word first appears on `code_o`.
- R7: Table entries at an index at or above `match_cnt` never cause a match, but `code_o` is still updated.
- R8: When `match_en[i]` is 0, channel i still updates its code output but never raises `wake_irq[i]`.
- R9: Channels decode independently. Two channels that complete frames in the same cycle each raise their own interrupt bit according to their own word.
- R10: A data-bit high that lies in both the zero window and the one window is decoded as a 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ir_in | input | NUM_CH | Infrared input line per channel, idle high |
| win_ldr_lo | input | 2*WID_W | Leader low window {max, min} |
| win_ldr_hi | input | 2*WID_W | Leader high window {max, min} |
| win_dat_lo | input | 2*WID_W | Data-bit low window {max, min} |
| win_zero_hi | input | 2*WID_W | High window for a 0 bit {max, min} |
| win_one_hi | input | 2*WID_W | High window for a 1 bit {max, min} |
| match_tbl | input | MAX_CODES*CODE_W | Wake code table, entry j at bits j*CODE_W |
| match_cnt | input | $clog2(MAX_CODES+1) | Number of active table entries |
| match_en | input | NUM_CH | Per-channel matching enable |
| wake_irq | output | NUM_CH | One-cycle wake pulse per channel |
| code_o | output | NUM_CH*CODE_W | Last decoded word per channel |

## Verification
The two functions that can coincide are the completions of frames on two channels, which may land in the same clock cycle. Both channels are driven by the same timing with different words: one word is in the table, and in a second run both words are in the table. The pass criterion is that each interrupt bit and each code slice reflects only its own channel's word. Window edges are probed with leader widths at the minimum, at the maximum and one below the minimum. Abort paths are judged by checking that `code_o` keeps its previous value and that the interrupt counters do not move.

// File: rtl/ir_wake_matcher.sv
module ir_wake_matcher #(
  parameter int NUM_CH    = 2,
  parameter int CODE_W    = 32,
  parameter int WID_W     = 12,
  parameter int MAX_CODES = 4,
  parameter int PRESC     = 16
) (
  input  logic                          clk,
  input  logic                          rst_n,
  input  logic [NUM_CH-1:0]             ir_in,
  input  logic [2*WID_W-1:0]            win_ldr_lo,
  input  logic [2*WID_W-1:0]            win_ldr_hi,
  input  logic [2*WID_W-1:0]            win_dat_lo,
  input  logic [2*WID_W-1:0]            win_zero_hi,
  input  logic [2*WID_W-1:0]            win_one_hi,
  input  logic [MAX_CODES*CODE_W-1:0]   match_tbl,
  input  logic [$clog2(MAX_CODES+1)-1:0] match_cnt,
  input  logic [NUM_CH-1:0]             match_en,
  output logic [NUM_CH-1:0]             wake_irq,
  output logic [NUM_CH*CODE_W-1:0]      code_o
);
  localparam int CNT_W = $clog2(MAX_CODES+1);
  localparam int BIT_W = (CODE_W > 1) ? $clog2(CODE_W) : 1;
  localparam int PS_W  = (PRESC > 1) ? $clog2(PRESC) : 1;

  typedef enum logic [2:0] {S_IDLE, S_LL, S_LH, S_DL, S_DH} st_t;

  logic [PS_W-1:0] ps_q;
  wire tick = (ps_q == PS_W'(PRESC-1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) ps_q <= '0;
    else        ps_q <= tick ? '0 : ps_q + 1'b1;

  function automatic logic in_win(input logic [WID_W-1:0] w, input logic [2*WID_W-1:0] win);
    return (w >= win[WID_W-1:0]) && (w <= win[2*WID_W-1:WID_W]);
  endfunction

  function automatic logic tbl_hit(input logic [CODE_W-1:0] word,
                                   input logic [MAX_CODES*CODE_W-1:0] tbl,
                                   input logic [CNT_W-1:0] cnt);
    logic hit;
    hit = 1'b0;
    for (int j = 0; j < MAX_CODES; j++)
      if ((CNT_W'(j) < cnt) && (tbl[j*CODE_W +: CODE_W] == word)) hit = 1'b1;
    return hit;
  endfunction

  for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
    logic [1:0]        sync_q;
    logic              prev_q;
    st_t               st_q;
    logic [WID_W-1:0]  w_q;
    logic [BIT_W-1:0]  nb_q;
    logic [CODE_W-1:0] sh_q, code_q;
    logic              irq_q;

    wire lvl     = sync_q[1];
    wire edge_w  = lvl ^ prev_q;
    wire is_zero = in_win(w_q, win_zero_hi);
    wire is_one  = in_win(w_q, win_one_hi);
    wire last    = (nb_q == BIT_W'(CODE_W-1));
    wire [CODE_W-1:0] nxt_sh = {~is_zero, sh_q[CODE_W-1:1]};

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        sync_q <= 2'b11;
        prev_q <= 1'b1;
        st_q   <= S_IDLE;
        w_q    <= '0;
        nb_q   <= '0;
        sh_q   <= '0;
        code_q <= '0;
        irq_q  <= 1'b0;
      end else begin
        sync_q <= {sync_q[0], ir_in[c]};
        prev_q <= lvl;
        irq_q  <= 1'b0;
        if (edge_w)                 w_q <= WID_W'(tick);
        else if (tick && w_q != '1) w_q <= w_q + 1'b1;
        if (edge_w) begin
          case (st_q)
            S_IDLE: if (!lvl) st_q <= S_LL;
            S_LL:   st_q <= in_win(w_q, win_ldr_lo) ? S_LH : S_IDLE;
            S_LH: begin
              nb_q <= '0;
              st_q <= in_win(w_q, win_ldr_hi) ? S_DL : S_IDLE;
            end
            S_DL:   st_q <= in_win(w_q, win_dat_lo) ? S_DH : S_IDLE;
            S_DH: begin
              if (is_zero || is_one) begin
                sh_q <= nxt_sh;
                nb_q <= nb_q + 1'b1;
                st_q <= S_DL;
                if (last) begin
                  code_q <= nxt_sh;
                  irq_q  <= match_en[c] && tbl_hit(nxt_sh, match_tbl, match_cnt);
                  nb_q   <= '0;
                  st_q   <= S_IDLE;
                end
              end else begin
                st_q <= S_IDLE;
              end
            end
            default: st_q <= S_IDLE;
          endcase
        end
      end
    end

    assign wake_irq[c]                 = irq_q;
    assign code_o[c*CODE_W +: CODE_W]  = code_q;
  end
endmodule

// File: rtl/ir_wake_matcher_chk.sv
module ir_wake_matcher_chk #(
  parameter int NUM_CH    = 2,
  parameter int CODE_W    = 32,
  parameter int MAX_CODES = 4
) (
  input logic                           clk,
  input logic                           rst_n,
  input logic [$clog2(MAX_CODES+1)-1:0] match_cnt,
  input logic [NUM_CH-1:0]              match_en,
  input logic [NUM_CH-1:0]              wake_irq,
  input logic [NUM_CH*CODE_W-1:0]       code_o
);
  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    !rst_n |=> (wake_irq == '0) && (code_o == '0));

  // R6
  irq_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wake_irq & $past(wake_irq)) == '0));

  // R7
  empty_table_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(match_cnt) == '0) |-> (wake_irq == '0));

  // R8
  enable_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((wake_irq & ~$past(match_en)) == '0));
endmodule

bind ir_wake_matcher ir_wake_matcher_chk #(
  .NUM_CH(NUM_CH), .CODE_W(CODE_W), .MAX_CODES(MAX_CODES)
) chk_i (
  .clk(clk), .rst_n(rst_n), .match_cnt(match_cnt), .match_en(match_en),
  .wake_irq(wake_irq), .code_o(code_o)
);

// File: tb/ir_wake_matcher_tb_top.sv
module ir_wake_matcher_tb_top;
  localparam int NCH = 2, CW = 32, WW = 12, MC = 4;

  logic clk = 1'b0, rst_n = 1'b0;
  logic ir0 = 1'b1, ir1 = 1'b1;
  logic [2*WW-1:0] w_ll, w_lh, w_dl, w_zh, w_oh;
  logic [MC*CW-1:0] tbl;
  logic [$clog2(MC+1)-1:0] cnt;
  logic [NCH-1:0] en;
  logic [NCH-1:0] irq;
  logic [NCH*CW-1:0] code;

  int tests = 0, fails = 0;
  int hits0 = 0, hits1 = 0;
  bit done = 0;

  localparam logic [31:0] C0 = 32'h1234_5678, C1 = 32'hCAFE_0001,
                          C2 = 32'h8000_0001, C3 = 32'h0F0F_00FF;

  always #5 clk = ~clk;

  ir_wake_matcher #(.NUM_CH(NCH), .CODE_W(CW), .WID_W(WW), .MAX_CODES(MC), .PRESC(1)) dut_i (
    .clk(clk), .rst_n(rst_n), .ir_in({ir1, ir0}),
    .win_ldr_lo(w_ll), .win_ldr_hi(w_lh), .win_dat_lo(w_dl),
    .win_zero_hi(w_zh), .win_one_hi(w_oh),
    .match_tbl(tbl), .match_cnt(cnt), .match_en(en),
    .wake_irq(irq), .code_o(code));

  always @(posedge clk) begin
    if (irq[0]) hits0++;
    if (irq[1]) hits1++;
  end

  function automatic logic [2*WW-1:0] mk(input int mn, input int mx);
    return {WW'(mx), WW'(mn)};
  endfunction

  task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic drv(input int ch, input logic v, input int n);
    if (ch == 0) ir0 = v; else ir1 = v;
    repeat (n) @(negedge clk);
  endtask

  task automatic send(input int ch, input logic [31:0] c, input int ll, input int zh);
    drv(ch, 1'b0, ll);
    drv(ch, 1'b1, 8);
    for (int b = 0; b < CW; b++) begin
      drv(ch, 1'b0, 3);
      drv(ch, 1'b1, c[b] ? 7 : zh);
    end
    drv(ch, 1'b0, 3);
    drv(ch, 1'b1, 20);
  endtask

  task automatic t_reset;
    chk("R1 irq at reset", 64'(irq), 64'd0);
    chk("R1 code at reset", 64'(code), 64'd0);
  endtask

  task automatic t_basic;
    int h;
    h = hits0;
    send(0, C0, 16, 3);
    chk("R2 code lsb-first", 64'(code[31:0]), 64'(C0));
    chk("R6 match pulse", 64'(hits0 - h), 64'd1);
    h = hits0;
    send(0, C1, 16, 3);
    chk("R2 second pattern", 64'(code[31:0]), 64'(C1));
    chk("R6 second entry match", 64'(hits0 - h), 64'd1);
  endtask

  task automatic t_bounds;
    send(0, C2, 14, 3);
    chk("R3 width at min", 64'(code[31:0]), 64'(C2));
    send(0, C0, 18, 3);
    chk("R3 width at max", 64'(code[31:0]), 64'(C0));
    send(0, C3, 13, 3);
    chk("R3 below min rejected", 64'(code[31:0]), 64'(C0));
  endtask

  task automatic t_leader;
    int h;
    h = hits0;
    send(0, C1, 30, 3);
    chk("R4 bad leader code kept", 64'(code[31:0]), 64'(C0));
    chk("R4 bad leader no irq", 64'(hits0 - h), 64'd0);
  endtask

  task automatic t_bad_bit;
    send(0, C3, 16, 5);
    chk("R5 bad bit code kept", 64'(code[31:0]), 64'(C0));
  endtask

  task automatic t_count;
    int h;
    h = hits0;
    send(0, C2, 16, 3);
    chk("R7 code updated", 64'(code[31:0]), 64'(C2));
    chk("R7 inactive entry no irq", 64'(hits0 - h), 64'd0);
    cnt = 3;
    h = hits0;
    send(0, C2, 16, 3);
    chk("R7 entry active after count raise", 64'(hits0 - h), 64'd1);
  endtask

  task automatic t_enable;
    int h;
    en = 2'b10;
    h = hits0;
    send(0, C0, 16, 3);
    chk("R8 code updated when disabled", 64'(code[31:0]), 64'(C0));
    chk("R8 no irq when disabled", 64'(hits0 - h), 64'd0);
    en = 2'b11;
  endtask

  task automatic t_dual;
    int h0, h1;
    h0 = hits0; h1 = hits1;
    fork
      send(0, C1, 16, 3);
      send(1, C3, 16, 3);
    join
    chk("R9 ch0 code", 64'(code[31:0]), 64'(C1));
    chk("R9 ch1 code", 64'(code[63:32]), 64'(C3));
    chk("R9 ch0 irq", 64'(hits0 - h0), 64'd1);
    chk("R9 ch1 unmatched", 64'(hits1 - h1), 64'd0);
    tbl[3*CW +: CW] = C3; cnt = 4;
    h0 = hits0; h1 = hits1;
    fork
      send(0, C0, 16, 3);
      send(1, C3, 16, 3);
    join
    chk("R9 both irq ch0", 64'(hits0 - h0), 64'd1);
    chk("R9 both irq ch1", 64'(hits1 - h1), 64'd1);
  endtask

  task automatic t_overlap;
    w_oh = mk(2, 8);
    send(1, C2, 16, 3);
    chk("R10 overlap decodes zero", 64'(code[63:32]), 64'(C2));
    w_oh = mk(6, 8);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1;
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    w_ll = mk(14, 18); w_lh = mk(6, 10); w_dl = mk(2, 4);
    w_zh = mk(2, 4);   w_oh = mk(6, 8);
    tbl = '0;
    tbl[0*CW +: CW] = C0; tbl[1*CW +: CW] = C1;
    tbl[2*CW +: CW] = C2; tbl[3*CW +: CW] = 32'hDEAD_BEEF;
    cnt = 2; en = 2'b11;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    t_reset();
    t_basic();
    t_bounds();
    t_leader();
    t_bad_bit();
    t_count();
    t_enable();
    t_dual();
    t_overlap();
    finish_run();
  end
endmodule